// File: doc/BRIEF.md
# Averaging ADC Controller Register Block

This block is the digital controller for a ten-channel, twelve-bit successive-approximation converter whose analog core sits outside it. Software programs it through a simple 32-bit word-addressed write bus with a combinational read port. After software selects a channel, an averaging depth N and an evaluation time, a start command makes the block run 2^N back-to-back conversion steps on that channel. Each step opens with a one-cycle sample request to an external sample port. The port returns a 12-bit raw code, which the block takes on the last cycle of the step.

The block sums the codes, divides the sum by 2^N with truncation and formats the result as straight binary or two's complement. It places the result in the data register, raises a conversion-end status flag and sets a sticky interrupt flag. The interrupt output is driven only when software has enabled it. A soft-reset command returns every register to its default. A stop command aborts a running conversion.

Top module: `avg_adc_ctrl`

## Requirements
- R1: After reset, the control 1, control 2, status, data, interrupt enable and interrupt status registers (offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14) read 0. The word at 0x20 reads 0x80000008, and irq is low.
- R2: The word at 0x20 is read-only: a write to it leaves its value 0x80000008.
- R3: Control 2 (0x04) stores these fields and reads them back:
  - bits 3:0, the channel;
  - bits 6:4, N;
  - bit 8, the rate mode;
  - bit 9, the evaluation time select;
  - bit 10, the format.
  All other bits read 0.
- R4: A write to 0x00 with bit 0 set and bit 2 clear, while the channel is 0 to 9, starts a conversion. It produces 2^N one-cycle pulses on smp_req, spaced T cycles apart, with the first pulse in the cycle after the write. smp_chan carries the channel. T is 20 when control 2 bit 9 is 1 and 40 when it is 0.
- R5: On completion, data (0x0C) bits 11:0 take the truncated mean, floor(sum of codes / 2^N), when control 2 bit 10 is 1. When that bit is 0, they take the mean with bit 11 inverted. Bits 31:12 read 0, and the full-scale input does not overflow at N=7.
- R6: Status bit 2 (0x08) reads 0 from the start until T*2^N cycles after the start write, and reads 1 from then on. A new start clears it.
- R7: A start while the channel field is 10 to 15 is ignored: no smp_req pulse appears, and data and status keep their values.
- R8: A write to 0x00 with bit 0 and bit 2 clear aborts a running conversion. After it, no smp_req pulse appears, data is unchanged, status bit 2 stays 0 and interrupt status stays unchanged.
- R9: Interrupt status bit 0 (0x14) is set on each completion. Writing 1 to it clears it. irq equals interrupt status bit 0 AND interrupt enable bit 0 (0x10).
- R10: A write to 0x00 with bit 2 set aborts any conversion and returns all registers to their reset values, even if bit 0 is also set.
- R11: Channel, N, evaluation time and format are captured at start. A control 2 write during a conversion changes only the read-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| smp_req | output | 1 | One-cycle request opening each conversion step |
| smp_chan | output | 4 | Channel latched for the running conversion |
| smp_code | input | 12 | Raw code from the sample port |
| irq | output | 1 | Interrupt, pending flag gated by enable |

## Verification
The averaging path is exercised with four code patterns:
- A constant code, which separates a correct divide from a shift by the wrong depth.
- A ramp, whose sum exposes a lost or duplicated step.
- A scattered sequence, whose truncation exposes rounding.
- A full-scale code at the deepest average, which exposes an accumulator that is too narrow.

Both output formats and both evaluation times are used, so an inverted format bit or a swapped step length appears in the data value or in the timing of the request pulses. Invalid-channel starts, aborts, a control write during a run and a soft reset combined with start each show whether the data, status and interrupt state were left alone or reset.

// File: rtl/avg_adc_pkg.sv
// Shared constants and types of the averaging ADC controller.
// Assumes a word-aligned byte address map and a 4-bit channel field.
package avg_adc_pkg;
    localparam int CH_W   = 4;
    localparam int LOGN_W = 3;

    localparam int A_CTRL1  = 'h00;
    localparam int A_CTRL2  = 'h04;
    localparam int A_STATUS = 'h08;
    localparam int A_DATA   = 'h0C;
    localparam int A_INTEN  = 'h10;
    localparam int A_INTST  = 'h14;
    localparam int A_VER    = 'h20;

    localparam logic [31:0] VERSION_WORD = 32'h8000_0008;

    typedef struct packed {
        logic            fmt_bin;
        logic            eval20;
        logic            fast;
        logic [LOGN_W-1:0] log2n;
        logic [CH_W-1:0] chan;
    } cfg_t;
endpackage

// File: rtl/avg_adc_seq.sv
// Conversion sequencer and averaging accumulator.
// Runs 2^N steps of T cycles each on the configuration latched at start,
// captures the sample code on the last cycle of each step, and presents the
// formatted mean together with a one-cycle fin pulse.
// Assumes start, stop and srst are never asserted together with each other
// except srst, which dominates.
module avg_adc_seq
    import avg_adc_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int EVAL_SHORT = 20,
    parameter int EVAL_LONG  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              start,
    input  logic              stop,
    input  cfg_t              cfg,
    input  logic [CODE_W-1:0] smp_code,
    output logic              smp_req,
    output logic [CH_W-1:0]   smp_chan,
    output logic              fin,
    output logic [CODE_W-1:0] result
);
    localparam int IDX_W = (1 << LOGN_W) - 1;
    localparam int ACC_W = CODE_W + IDX_W;
    localparam int TW    = $clog2(EVAL_LONG);

    logic              busy;
    logic [TW-1:0]     cnt;
    logic [IDX_W-1:0]  idx;
    logic [ACC_W-1:0]  acc;
    cfg_t              lcfg;

    logic [TW-1:0]     tlim;
    logic [IDX_W:0]    nsmp;
    logic              step_end;
    logic              last;
    logic [ACC_W-1:0]  sum;
    logic [ACC_W-1:0]  avg_full;
    logic [CODE_W-1:0] avg;

    // Step length, sample count and the running sum including this step.
    always_comb begin
        tlim     = lcfg.eval20 ? TW'(EVAL_SHORT - 1) : TW'(EVAL_LONG - 1);
        nsmp     = {{IDX_W{1'b0}}, 1'b1} << lcfg.log2n;
        step_end = busy && (cnt == tlim);
        last     = ({1'b0, idx} == (nsmp - 1'b1));
        sum      = acc + {{IDX_W{1'b0}}, smp_code};
        avg_full = sum >> lcfg.log2n;
        avg      = avg_full[CODE_W-1:0];
        result   = lcfg.fmt_bin ? avg : {~avg[CODE_W-1], avg[CODE_W-2:0]};
        fin      = step_end && last && !start && !stop && !srst;
        smp_req  = busy && (cnt == '0);
        smp_chan = lcfg.chan;
    end

    // Sequencer state: launch, abort, step counting and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            busy <= 1'b0;
            cnt  <= '0;
            idx  <= '0;
            acc  <= '0;
            lcfg <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            idx  <= '0;
            acc  <= '0;
            lcfg <= cfg;
        end else if (stop) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (step_end) begin
                cnt <= '0;
                acc <= sum;
                if (last) busy <= 1'b0;
                else      idx  <= idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_start_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !srst) |=> smp_req);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= tlim));
    p_fin_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !srst) |=> !smp_req);
endmodule

// File: rtl/avg_adc_regs.sv
// Register file, command decode and interrupt logic.
// Decodes start, stop and soft reset from control 1 writes, holds the
// configuration, data, conversion-end and interrupt flags, and drives the
// combinational read mux. Assumes fin and its result arrive in the same cycle.
module avg_adc_regs
    import avg_adc_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int NCH    = 10,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fin,
    input  logic [CODE_W-1:0] fin_val,
    output logic              start,
    output logic              stop,
    output logic              srst,
    output cfg_t              cfg,
    output logic              irq
);
    logic              done_q;
    logic              int_en_q;
    logic              int_st_q;
    logic [CODE_W-1:0] data_q;
    logic              w_c1, w_c2, w_ie, w_is;

    // Write strobes and command decode for control 1.
    always_comb begin
        w_c1  = bus_wr && (bus_addr == ADDR_W'(A_CTRL1));
        w_c2  = bus_wr && (bus_addr == ADDR_W'(A_CTRL2));
        w_ie  = bus_wr && (bus_addr == ADDR_W'(A_INTEN));
        w_is  = bus_wr && (bus_addr == ADDR_W'(A_INTST));
        srst  = w_c1 && bus_wdata[2];
        start = w_c1 && !bus_wdata[2] && bus_wdata[0] && (int'(cfg.chan) < NCH);
        stop  = w_c1 && !bus_wdata[2] && !bus_wdata[0];
        irq   = int_st_q && int_en_q;
    end

    // Register storage with soft reset, completion capture and W1C.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            cfg      <= '0;
            done_q   <= 1'b0;
            int_en_q <= 1'b0;
            int_st_q <= 1'b0;
            data_q   <= '0;
        end else begin
            if (w_c2) begin
                cfg.chan    <= bus_wdata[3:0];
                cfg.log2n   <= bus_wdata[6:4];
                cfg.fast    <= bus_wdata[8];
                cfg.eval20  <= bus_wdata[9];
                cfg.fmt_bin <= bus_wdata[10];
            end
            if (w_ie) int_en_q <= bus_wdata[0];
            if (fin)                      int_st_q <= 1'b1;
            else if (w_is && bus_wdata[0]) int_st_q <= 1'b0;
            if (start)    done_q <= 1'b0;
            else if (fin) done_q <= 1'b1;
            if (fin) data_q <= fin_val;
        end
    end

    // Combinational read mux; unmapped words read zero.
    always_comb begin
        case (bus_addr)
            ADDR_W'(A_CTRL2):  bus_rdata = {21'b0, cfg.fmt_bin, cfg.eval20, cfg.fast,
                                            1'b0, cfg.log2n, cfg.chan};
            ADDR_W'(A_STATUS): bus_rdata = {29'b0, done_q, 2'b0};
            ADDR_W'(A_DATA):   bus_rdata = {{(32-CODE_W){1'b0}}, data_q};
            ADDR_W'(A_INTEN):  bus_rdata = {31'b0, int_en_q};
            ADDR_W'(A_INTST):  bus_rdata = {31'b0, int_st_q};
            ADDR_W'(A_VER):    bus_rdata = VERSION_WORD;
            default:           bus_rdata = 32'b0;
        endcase
    end

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_is && bus_wdata[0] && !fin) |=> !int_st_q);
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fin && !srst) |=> $stable(data_q));
    p_start_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_q);
    p_srst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!done_q && !int_st_q && !irq));
endmodule

// File: rtl/avg_adc_ctrl.sv
// Top of the averaging ADC controller: register block plus sequencer.
// Assumes a single-cycle write bus and a sample port whose code is stable
// from the request until the end of the step.
module avg_adc_ctrl
    import avg_adc_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int NCH        = 10,
    parameter int ADDR_W     = 6,
    parameter int EVAL_SHORT = 20,
    parameter int EVAL_LONG  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              smp_req,
    output logic [CH_W-1:0]   smp_chan,
    input  logic [CODE_W-1:0] smp_code,
    output logic              irq
);
    logic              start, stop, srst, fin;
    logic [CODE_W-1:0] fin_val;
    cfg_t              cfg;

    avg_adc_regs #(.CODE_W(CODE_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fin(fin),
        .fin_val(fin_val), .start(start), .stop(stop), .srst(srst),
        .cfg(cfg), .irq(irq)
    );

    avg_adc_seq #(.CODE_W(CODE_W), .EVAL_SHORT(EVAL_SHORT), .EVAL_LONG(EVAL_LONG)) u_seq (
        .clk(clk), .rst_n(rst_n), .srst(srst), .start(start), .stop(stop),
        .cfg(cfg), .smp_code(smp_code), .smp_req(smp_req),
        .smp_chan(smp_chan), .fin(fin), .result(fin_val)
    );
endmodule

// File: tb/avg_adc_ctrl_test.sv
// Bench for the averaging ADC controller with a behavioural reference model.
module avg_adc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_req;
    logic [3:0]  smp_chan;
    logic [11:0] smp_code = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit started = 0;
    int g_seed = 0;
    int g_base = 0;

    // Model state.
    int m_ctrl2 = 0, m_data = 0, m_ien = 0;
    bit m_done = 0, m_int = 0, m_active = 0, m_fmt = 0;
    int m_el = 0, m_T = 0, m_N = 0, m_tot = 0, m_ch = 0;
    int q[$];
    bit c1, st_ok, sp, fin_now;

    always #5 clk = ~clk;

    avg_adc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_req(smp_req),
        .smp_chan(smp_chan), .smp_code(smp_code), .irq(irq)
    );

    function automatic int gen(int k);
        return (g_seed * (k + 1) * 97 + g_base) % 4096;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model, updated at each clock edge from the stimulus.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl2 = 0; m_data = 0; m_ien = 0; m_done = 0; m_int = 0; m_active = 0;
        end else begin
            c1    = bus_wr && bus_addr == 6'h00;
            st_ok = c1 && !bus_wdata[2] && bus_wdata[0] && ((m_ctrl2 & 15) <= 9);
            sp    = c1 && !bus_wdata[2] && !bus_wdata[0];
            fin_now = m_active && (m_el == m_tot - 1) && !st_ok && !sp;
            if (c1 && bus_wdata[2]) begin
                m_ctrl2 = 0; m_data = 0; m_ien = 0; m_done = 0; m_int = 0; m_active = 0;
            end else begin
                if (fin_now) begin
                    int s;
                    s = 0;
                    foreach (q[i]) s += q[i];
                    s = s >> m_N;
                    m_data = m_fmt ? s : (s ^ 'h800);
                    m_done = 1; m_int = 1; m_active = 0;
                end else if (m_active) m_el++;
                if (st_ok) begin
                    m_active = 1; m_el = 0;
                    m_T = m_ctrl2[9] ? 20 : 40;
                    m_N = (m_ctrl2 >> 4) & 7;
                    m_fmt = m_ctrl2[10];
                    m_ch = m_ctrl2 & 15;
                    m_tot = m_T << m_N;
                    m_done = 0;
                    q.delete();
                end else if (sp) m_active = 0;
                if (bus_wr && bus_addr == 6'h04) m_ctrl2 = bus_wdata & 'h77F;
                if (bus_wr && bus_addr == 6'h10) m_ien = bus_wdata & 1;
                if (bus_wr && bus_addr == 6'h14 && bus_wdata[0] && !fin_now) m_int = 0;
            end
        end
    end

    // Per-clock comparison of request pulses, channel and interrupt.
    always @(negedge clk) begin
        if (started) begin
            chk("R4 smp_req", smp_req, m_active && (m_el % m_T == 0));
            if (smp_req) chk("R4 smp_chan", smp_chan, m_ch);
            chk("R9 irq", irq, m_int && m_ien);
        end
    end

    // Sample port: a new code for every request.
    always @(negedge clk) begin
        if (started && smp_req) begin
            smp_code <= 12'(gen(q.size()));
            q.push_back(gen(q.size()));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string tag, int a, int exp);
        @(negedge clk);
        bus_addr = 6'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(int c2, int seed, int base);
        g_seed = seed; g_base = base;
        wr('h04, c2);
        wr('h00, 1);
        rd("R6 status busy", 'h08, 0);
        wait_idle();
        rd("R5 data", 'h0C, m_data);
        rd("R6 status done", 'h08, 4);
        rd("R9 int status set", 'h14, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R1: reset values.
        rd("R1 ctrl1", 'h00, 0);
        rd("R1 ctrl2", 'h04, 0);
        rd("R1 status", 'h08, 0);
        rd("R1 data", 'h0C, 0);
        rd("R1 inten", 'h10, 0);
        rd("R1 intst", 'h14, 0);
        rd("R1 version", 'h20, 'h80000008);
        chk("R1 irq", irq, 0);
        // R2: version is read-only.
        wr('h20, 0);
        rd("R2 version", 'h20, 'h80000008);
        // R3: control 2 field readback.
        wr('h04, 'hFFFFFFFF);
        rd("R3 ctrl2 mask", 'h04, 'h77F);
        wr('h04, 'h125);
        rd("R3 ctrl2 value", 'h04, 'h125);
        // Ramp, N=3, T=20, binary, channel 5, interrupt enabled.
        wr('h10, 1);
        run('h735, 1, 10);
        chk("R5 ramp mean", m_data, ((10+97)+(10+194)+(10+291)+(10+388)+(10+485)+(10+582)+(10+679)+(10+776)) >> 3);
        // R9: write-one-to-clear.
        wr('h14, 0);
        rd("R9 intst keeps on 0", 'h14, 1);
        wr('h14, 1);
        rd("R9 intst cleared", 'h14, 0);
        // Two's complement, N=0, T=40, channel 9.
        run('h009, 0, 'h123);
        chk("R5 twos comp", m_data, 'h923);
        wr('h14, 1);
        // Full scale at N=7, T=20.
        run('h670, 0, 4095);
        chk("R5 full scale", m_data, 'hFFF);
        // Scattered codes, N=2, T=40, binary, channel 7.
        run('h427, 53, 777);
        wr('h14, 1);
        // R7: invalid channel start is ignored.
        wr('h04, 'h60C);
        wr('h00, 1);
        repeat (60) @(negedge clk);
        rd("R7 data unchanged", 'h0C, m_data);
        rd("R7 status unchanged", 'h08, 4);
        rd("R7 intst unchanged", 'h14, 0);
        // R8: stop aborts.
        g_seed = 3; g_base = 5;
        wr('h04, 'h422);
        wr('h00, 1);
        repeat (30) @(negedge clk);
        wr('h00, 0);
        repeat (300) @(negedge clk);
        rd("R8 status stays 0", 'h08, 0);
        rd("R8 data unchanged", 'h0C, m_data);
        rd("R8 intst unchanged", 'h14, 0);
        // R11: control 2 write during a run does not disturb it.
        g_seed = 7; g_base = 100;
        wr('h04, 'h613);
        wr('h00, 1);
        repeat (5) @(negedge clk);
        wr('h04, 'h005);
        wait_idle();
        rd("R11 data from latched cfg", 'h0C, m_data);
        rd("R11 ctrl2 readback", 'h04, 'h005);
        chk("R11 latched mean", m_data, ((100+7*97)+(100+14*97)) >> 1);
        // R10: soft reset with start, during a run.
        wr('h04, 'h735);
        wr('h00, 1);
        repeat (10) @(negedge clk);
        wr('h00, 5);
        rd("R10 ctrl2", 'h04, 0);
        rd("R10 status", 'h08, 0);
        rd("R10 data", 'h0C, 0);
        rd("R10 inten", 'h10, 0);
        rd("R10 intst", 'h14, 0);
        repeat (50) @(negedge clk);
        chk("R10 irq", irq, 0);
        started = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule